// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a bus target for a two-wire serial control bus. It holds a bank of 8-bit configuration registers that a host controller reaches through a subaddress pointer. Both bus lines are oversampled with the system clock. The block finds start and stop conditions, compares the device address with its own, and then either stores a stream of bytes or returns one. The pointer advances by one after every byte.

The device address is fixed by a parameter except for one bit, which comes from a strapping input. Two instances can therefore share a bus. A write transfer carries the starting subaddress in its first data byte. A read is done as a subaddress write, then a repeated start, then an address byte with the direction bit set. The data line is open-drain: the block only ever pulls it low or releases it.

Top module: `cfgi2c_target`

## Requirements
- R1: The target answers the address byte `{DEV_UPPER, addr_strap, rw}` (bit 0 is rw, where 1 means read; bit 1 is the strap). With the defaults this is 0x40/0x41 when the strap is low and 0x42/0x43 when it is high. It acknowledges by pulling SDA low during the ninth SCL clock of the byte.
- R2: An address byte that does not match is not acknowledged. SDA stays released, and every following byte is ignored until the next start condition.
- R3: The first byte after a matching write address is the subaddress. Values 0x00 to 0xF8 are acknowledged and loaded into the pointer. Any larger value is not acknowledged, and the target goes idle.
- R4: Each later write byte is stored in the register at the pointer and acknowledged, and then the pointer increments.
- R5: A write byte that arrives while the pointer is above 0xF8 is not stored and not acknowledged, and the target goes idle.
- R6: After a matching read address, the target sends the register at the pointer, MSB first, with each bit changing while SCL is low. After each byte it advances the pointer.
- R7: Once the pointer is at 0xF8 or beyond, every further read byte returns the contents of register 0xF8.
- R8: When the controller does not acknowledge a read byte, the target releases SDA and sends nothing more until a new start condition.
- R9: A start or stop condition that arrives in the middle of a byte aborts the transfer without storing the partial byte. A start then begins a new address phase.
- R10: The pointer keeps its value across a stop. A read with no new subaddress continues from the last pointer value.
- R11: After reset, all registers and the pointer are zero and SDA is released.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (resolved bus value) |
| addr_strap | input | 1 | Strap that sets bit 1 of the address byte |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench targets the pointer edges. It writes to 0xF8 and then sends one byte more; a design that wrapped the pointer would overwrite register 0x00 instead of refusing the byte. It reads across the top, so a design that kept counting would return stale or zero data instead of repeating register 0xF8. It also breaks a byte with a start or a stop, so a design that committed partial shifts would leave a register changed. It tries the wrong strap address and data bytes after a refusal, so a design that recovered too early would acknowledge traffic meant for another device.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_SUB,
        PH_SUB_ACK,
        PH_WDATA,
        PH_WDATA_ACK,
        PH_RDATA,
        PH_RACK
    } phase_e;

endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    // chain[0] is the first flop; chain[STAGES] is one sample older than q
    logic [STAGES:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], d};
    end

    assign q    = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank #(
    parameter int REG_COUNT = 249,
    parameter int IDX_W     = $clog2(REG_COUNT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IDX_W-1:0]             waddr,
    input  logic [cfgi2c_pkg::BYTE_W-1:0] wdata,
    input  logic [IDX_W-1:0]             raddr,
    output logic [cfgi2c_pkg::BYTE_W-1:0] rdata
);
    logic [REG_COUNT-1:0][cfgi2c_pkg::BYTE_W-1:0] rd_vec;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        logic [cfgi2c_pkg::BYTE_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           r <= '0;
            else if (we && waddr == IDX_W'(g))    r <= wdata;
        end
        assign rd_vec[g] = r;
    end

    assign rdata = rd_vec[raddr];
endmodule

// File: rtl/cfgi2c_target.sv
module cfgi2c_target #(
    parameter int          REG_COUNT   = 249,
    parameter logic [5:0]  DEV_UPPER   = 6'h10,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_strap,
    output logic sda_drive_low
);
    import cfgi2c_pkg::*;

    localparam int TOP_IDX = REG_COUNT - 1;
    localparam int IDX_W   = $clog2(REG_COUNT);
    localparam int PTR_W   = $clog2(REG_COUNT + 1);
    localparam int CNT_W   = 4;

    typedef struct packed {
        phase_e             st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [PTR_W-1:0]   ptr;
        logic               rw;
        logic               mack;
        logic               drv;
    } ctl_t;

    ctl_t q, d;

    logic [1:0] ln_s, ln_r, ln_f;
    logic       scl_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [BYTE_W-1:0] wr_data, rd_data;
    phase_e            st_cur;
    logic [PTR_W-1:0]  ptr_cur;

    cfgi2c_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}),
        .q(ln_s), .rise(ln_r), .fall(ln_f)
    );

    assign scl_s     = ln_s[1];
    assign scl_rise  = ln_r[1];
    assign scl_fall  = ln_f[1];
    assign start_det = scl_s & ln_f[0];
    assign stop_det  = scl_s & ln_r[0];

    assign rd_idx = (int'(q.ptr) > TOP_IDX) ? IDX_W'(TOP_IDX) : IDX_W'(q.ptr);

    cfgi2c_regbank #(.REG_COUNT(REG_COUNT), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_idx),
        .wdata(wr_data), .raddr(rd_idx), .rdata(rd_data)
    );

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_idx  = IDX_W'(q.ptr);
        wr_data = q.sh;
        if (start_det) begin
            d.st  = PH_ADDR;
            d.cnt = '0;
            d.drv = 1'b0;
        end else if (stop_det) begin
            d.st  = PH_IDLE;
            d.drv = 1'b0;
        end else begin
            case (q.st)
                PH_ADDR, PH_SUB, PH_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], ln_s[0]};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall && q.cnt == CNT_W'(8)) begin
                        d.st  = PH_IDLE;
                        d.drv = 1'b0;
                        if (q.st == PH_ADDR) begin
                            if (q.sh[7:1] == {DEV_UPPER, addr_strap}) begin
                                d.rw  = q.sh[0];
                                d.drv = 1'b1;
                                d.st  = PH_ADDR_ACK;
                            end
                        end else if (q.st == PH_SUB) begin
                            if (int'(q.sh) <= TOP_IDX) begin
                                d.ptr = PTR_W'(q.sh);
                                d.drv = 1'b1;
                                d.st  = PH_SUB_ACK;
                            end
                        end else if (int'(q.ptr) <= TOP_IDX) begin
                            wr_en = 1'b1;
                            d.ptr = q.ptr + PTR_W'(1);
                            d.drv = 1'b1;
                            d.st  = PH_WDATA_ACK;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh  = rd_data;
                            d.drv = ~rd_data[BYTE_W-1];
                            d.st  = PH_RDATA;
                        end else begin
                            d.drv = 1'b0;
                            d.st  = PH_SUB;
                        end
                    end
                end
                PH_SUB_ACK, PH_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        d.drv = 1'b0;
                        d.st  = PH_WDATA;
                    end
                end
                PH_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (q.cnt == CNT_W'(8)) begin
                            d.drv = 1'b0;
                            d.st  = PH_RACK;
                            d.ptr = (int'(q.ptr) < TOP_IDX) ? q.ptr + PTR_W'(1) : q.ptr;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.drv = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~ln_s[0];
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.sh  = rd_data;
                            d.drv = ~rd_data[BYTE_W-1];
                            d.st  = PH_RDATA;
                        end else begin
                            d.drv = 1'b0;
                            d.st  = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: PH_IDLE, cnt: '0, sh: '0, ptr: '0, rw: 1'b0, mack: 1'b0, drv: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_drive_low = q.drv;
    assign st_cur        = q.st;
    assign ptr_cur       = q.ptr;
endmodule

// File: rtl/cfgi2c_target_chk.sv
module cfgi2c_target_chk #(
    parameter int TOP_IDX = 248,
    parameter int PTR_W   = 8,
    parameter int IDX_W   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_drive_low,
    input cfgi2c_pkg::phase_e    st,
    input logic [PTR_W-1:0]      ptr,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      wr_idx,
    input logic                  start_det
);
    import cfgi2c_pkg::*;

    p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_i);

    p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE) |-> !sda_drive_low);

    p_addr_ack_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_ADDR_ACK) |-> sda_drive_low);

    p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) <= TOP_IDX));

    p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) <= TOP_IDX + 1);

    p_start_to_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == PH_ADDR));
endmodule

bind cfgi2c_target cfgi2c_target_chk #(
    .TOP_IDX(TOP_IDX), .PTR_W(PTR_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_drive_low(sda_drive_low),
    .st(st_cur), .ptr(ptr_cur), .wr_en(wr_en), .wr_idx(wr_idx),
    .start_det(start_det)
);

// File: tb/cfgi2c_target_bench.sv
module cfgi2c_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 6;

    typedef struct packed {
        logic [7:0] sub;
        logic [7:0] val;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{sub: 8'h00, val: 8'hA5},
        '{sub: 8'h10, val: 8'h3C},
        '{sub: 8'hF8, val: 8'h81},
        '{sub: 8'h7F, val: 8'hFF},
        '{sub: 8'h01, val: 8'h5A},
        '{sub: 8'h80, val: 8'h12}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic strap = 1'b0;
    logic sda_drive_low;
    wire  sda_line = m_sda & ~sda_drive_low;

    int n_tests = 0;
    int n_fail  = 0;
    int r12_viol = 0;
    logic prev_drv = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgi2c_target u_cfgi2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_strap(strap), .sda_drive_low(sda_drive_low)
    );

    // R12 monitor: drive may change only while SCL is low
    always begin
        @(posedge clk);
        #1;
        if (rst_n && sda_drive_low !== prev_drv && scl === 1'b1) r12_viol++;
        prev_drv = sda_drive_low;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(QTR);
        scl = 1'b1;   wait_clk(QTR);
        m_sda = 1'b0; wait_clk(QTR);
        scl = 1'b0;   wait_clk(QTR);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(QTR);
        scl = 1'b1;   wait_clk(QTR);
        m_sda = 1'b1; wait_clk(2*QTR);
    endtask

    task automatic bit_out(input logic b);
        wait_clk(QTR);
        m_sda = b;   wait_clk(QTR);
        scl = 1'b1;  wait_clk(2*QTR);
        scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; wait_clk(2*QTR);
        scl = 1'b1;   wait_clk(QTR);
        b = sda_line; wait_clk(QTR);
        scl = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic write1(input logic [7:0] sub, input logic [7:0] val, output logic ok);
        logic a0, a1, a2;
        bus_start();
        wbyte(8'h40, a0); wbyte(sub, a1); wbyte(val, a2);
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic read1(input logic [7:0] sub, output logic [7:0] v);
        logic a;
        bus_start();
        wbyte(8'h40, a); wbyte(sub, a);
        bus_start();
        wbyte(8'h41, a);
        rbyte(1'b0, v);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        logic ok, a;
        logic [7:0] v;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R11: reset state
        chk("R11 released", {7'd0, sda_drive_low}, 8'h00);
        read1(8'h05, v);
        chk("R11 reg zero", v, 8'h00);
        bus_start(); wbyte(8'h41, a); rbyte(1'b0, v); bus_stop();
        chk("R11 ptr zero", v, 8'hA5 & 8'h00);

        // Table walk: R3 R4 write, R6 read back
        foreach (VEC[k]) begin
            write1(VEC[k].sub, VEC[k].val, ok);
            chk("R4 write ack", {7'd0, ok}, 8'h01);
            read1(VEC[k].sub, v);
            chk("R6 readback", v, VEC[k].val);
        end

        // R1: strap high moves the address
        strap = 1'b1;
        bus_start(); wbyte(8'h42, a); chk("R1 strap addr ack", {7'd0, a}, 8'h01);
        wbyte(8'h11, a); wbyte(8'h77, a); bus_stop();
        bus_start(); wbyte(8'h40, a); chk("R1 old addr refused", {7'd0, a}, 8'h00);
        bus_stop();
        strap = 1'b0;
        read1(8'h11, v);
        chk("R1 strap write stored", v, 8'h77);

        // R2: mismatched address, later bytes ignored
        bus_start(); wbyte(8'h42, a); chk("R2 mismatch nack", {7'd0, a}, 8'h00);
        wbyte(8'h11, a); chk("R2 sub ignored", {7'd0, a}, 8'h00);
        wbyte(8'h99, a); bus_stop();
        read1(8'h11, v);
        chk("R2 reg untouched", v, 8'h77);

        // R3: invalid subaddress
        bus_start(); wbyte(8'h40, a); wbyte(8'hF9, a);
        chk("R3 F9 nack", {7'd0, a}, 8'h00);
        wbyte(8'h55, a); chk("R3 idle after nack", {7'd0, a}, 8'h00);
        bus_stop();

        // R4 R6: burst write and burst read
        bus_start(); wbyte(8'h40, a); wbyte(8'h20, a);
        wbyte(8'h01, a); wbyte(8'h02, a); wbyte(8'h03, a);
        chk("R4 burst ack", {7'd0, a}, 8'h01);
        bus_stop();
        bus_start(); wbyte(8'h40, a); wbyte(8'h20, a); bus_start(); wbyte(8'h41, a);
        rbyte(1'b1, v); chk("R6 burst 0", v, 8'h01);
        rbyte(1'b1, v); chk("R6 burst 1", v, 8'h02);
        rbyte(1'b0, v); chk("R6 burst 2", v, 8'h03);
        bus_stop();

        // R5: write past the top register
        bus_start(); wbyte(8'h40, a); wbyte(8'hF8, a); wbyte(8'hC3, a);
        chk("R5 top write ack", {7'd0, a}, 8'h01);
        wbyte(8'h5A, a); chk("R5 past top nack", {7'd0, a}, 8'h00);
        wbyte(8'h66, a); chk("R5 idle after", {7'd0, a}, 8'h00);
        bus_stop();
        read1(8'hF8, v); chk("R5 top kept", v, 8'hC3);
        read1(8'h00, v); chk("R5 no wrap", v, 8'hA5);

        // R7 R8: read across top, then controller NACK
        write1(8'hF7, 8'h9E, ok);
        bus_start(); wbyte(8'h40, a); wbyte(8'hF7, a); bus_start(); wbyte(8'h41, a);
        rbyte(1'b1, v); chk("R7 F7", v, 8'h9E);
        rbyte(1'b1, v); chk("R7 F8", v, 8'hC3);
        rbyte(1'b1, v); chk("R7 repeat top", v, 8'hC3);
        rbyte(1'b0, v); chk("R7 repeat top again", v, 8'hC3);
        wait_clk(4);
        chk("R8 released after nack", {7'd0, sda_drive_low}, 8'h00);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_in(b);
            v[i] = b;
        end
        chk("R8 silent after nack", v, 8'hFF);
        bus_stop();

        // R10: pointer kept across stop
        bus_start(); wbyte(8'h40, a); wbyte(8'h21, a); bus_stop();
        bus_start(); wbyte(8'h41, a); rbyte(1'b0, v); bus_stop();
        chk("R10 continue ptr", v, 8'h02);
        bus_start(); wbyte(8'h41, a); rbyte(1'b0, v); bus_stop();
        chk("R10 ptr advanced", v, 8'h03);

        // R9: start mid-byte aborts
        bus_start(); wbyte(8'h40, a); wbyte(8'h30, a);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        bus_start(); wbyte(8'h40, a);
        chk("R9 new address after start", {7'd0, a}, 8'h01);
        bus_stop();
        read1(8'h30, v); chk("R9 start abort no write", v, 8'h00);
        // R9: stop mid-byte aborts
        bus_start(); wbyte(8'h40, a); wbyte(8'h31, a);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
        bus_stop();
        read1(8'h31, v); chk("R9 stop abort no write", v, 8'h00);

        chk("R12 drive changes with SCL low", r12_viol[7:0], 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule